// File: doc/BRIEF.md
# Fixed-Segment Address Translator

This block turns a 64-bit virtual address into a physical address for a processor core that has no translation lookaside buffer. The mapping is fixed by architectural segments. Each segment strips a set number of high bits or applies a constant offset. Each segment also gives a cache attribute and a privilege rule.

The top bit of the virtual address acts as the privilege bit. Non-negative addresses are open to both modes. Negative addresses are open only to kernel mode, and supervisor accesses are presented as kernel. A narrow-address input marks a 32-bit address, which is sign-extended from bit 31 before it is decoded.

Outputs are combinational, or registered by one stage when `REG_OUT` is 1. A rejected access raises an address-error flag and returns a zero address with the uncached attribute. `PA_W` sets the physical address width.

Top module: `fixmap_xlat`

## Requirements
- R1: When `narrow_i` is 1, bits 63:32 of `vaddr_i` are ignored and taken to be copies of bit 31; when 0, the full 64-bit address is used.
- R2: With `kern_i` at 0 (user), any address with bit 63 set gives `aerr_o`=1, `paddr_o`=0 and `cached_o`=0; `kern_i` at 1 stands for both kernel and supervisor mode.
- R3: Addresses 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF keep only their low 29 bits, so both halves alias one 512 MB window: 0xFFFFFFFF80000000 gives 0 and 0xFFFFFFFFBFC00000 gives 0x1FC00000.
- R4: In that range, addresses below 0xFFFFFFFFA0000000 report `cached_o`=1 and addresses from 0xFFFFFFFFA0000000 up report `cached_o`=0.
- R5: Addresses 0xFFFFFFFFC0000000 to 0xFFFFFFFFFFFFFFFF map to their low 32 bits with `cached_o`=1.
- R6: With `erl_i` at 0, addresses 0 to 0x7FFFFFFF map to (address AND 0x7FFFFFFF) + 0x40000000 with `cached_o`=1, in both modes.
- R7: With `erl_i` at 1, addresses 0 to 0x7FFFFFFF map to themselves with `cached_o`=0.
- R8: Addresses 0x8000000000000000 to 0xBFFFFFFFFFFFFFFF drop bits 63:59. `cached_o` is 0 only when bits 61:59 equal 3'b010. When `PA_W` is below 59, any set bit between 58 and `PA_W` gives `aerr_o`=1.
- R9: Addresses 0x0000000080000000 to 0x7FFFFFFFFFFFFFFF and 0xC000000000000000 to 0xFFFFFFFF7FFFFFFF belong to no segment and give `aerr_o`=1, `paddr_o`=0 and `cached_o`=0 in either mode.
- R10: With `REG_OUT`=1, each output shows the result for the inputs of the previous clock edge, and all outputs are 0 during reset. When `vld_i` is 0, the result is `vld_o`=0, `aerr_o`=0, `paddr_o`=0 and `cached_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Request strobe |
| vaddr_i | input | 64 | Virtual address |
| narrow_i | input | 1 | 1: only bits 31:0 of the address are meaningful |
| kern_i | input | 1 | 1: kernel or supervisor mode, 0: user mode |
| erl_i | input | 1 | Error-level flag; user addresses bypass the remap |
| vld_o | output | 1 | Result strobe |
| paddr_o | output | PA_W | Physical address, 0 on error |
| cached_o | output | 1 | 1: cacheable segment |
| aerr_o | output | 1 | Address error (privilege or unmapped) |

## Verification
The sweep targets the first and last address of every segment and the addresses just outside them. A decoder with an off-by-one range compare would misroute 0x7FFFFFFF, 0xFFFFFFFF7FFFFFFF or 0xFFFFFFFFC0000000. A wrong strip mask would break the aliasing of the exception base to 0 and the reset vector to 0x1FC00000.

Each point runs in user and kernel mode, with the error level set and clear, and in narrow mode with junk upper bits. This exposes four kinds of fault:
- a missing privilege check, which lets a user reach kernel space;
- a missing or wrong sign extension of narrow addresses;
- a misapplied error-level bypass;
- a cache attribute taken from the wrong address bit.

The physical window is run at a reduced width. Too-large addresses there must fault rather than wrap silently.

// File: rtl/fixmap_pkg.sv
package fixmap_pkg;
   localparam int VA_W      = 64;
   localparam int XPHYS_TOP = 59;   // bits kept by the physical window
   localparam int KSEG_KEEP = 29;   // bits kept by the compatibility segments

   typedef enum logic [2:0] {
      SEG_NONE,
      SEG_USER,
      SEG_KCACHED,
      SEG_KUNCACHED,
      SEG_KUPPER,
      SEG_XPHYS
   } seg_e;
endpackage

// File: rtl/fixmap_seg_decode.sv
module fixmap_seg_decode
   import fixmap_pkg::*;
#(
   parameter int PA_W = 59
) (
   input  logic [63:29] va_hi_i,
   input  logic         kern_i,
   output seg_e         seg_o,
   output logic         fault_o
);
   logic x_hi;

   generate
      if (PA_W < XPHYS_TOP) begin : g_short_pa
         assign x_hi = |va_hi_i[XPHYS_TOP-1:PA_W];
      end else begin : g_full_pa
         assign x_hi = 1'b0;
      end
   endgenerate

   always_comb begin
      seg_o = SEG_NONE;
      if (!va_hi_i[63]) begin
         if (va_hi_i[62:31] == '0) seg_o = SEG_USER;
      end else if (!va_hi_i[62]) begin
         if (!x_hi) seg_o = SEG_XPHYS;
      end else if (&va_hi_i[63:32]) begin
         case (va_hi_i[31:29])
            3'b100:         seg_o = SEG_KCACHED;
            3'b101:         seg_o = SEG_KUNCACHED;
            3'b110, 3'b111: seg_o = SEG_KUPPER;
            default:        seg_o = SEG_NONE;
         endcase
      end
      fault_o = (seg_o == SEG_NONE) | (va_hi_i[63] & ~kern_i);
   end
endmodule

// File: rtl/fixmap_phys_form.sv
module fixmap_phys_form
   import fixmap_pkg::*;
#(
   parameter int PA_W = 59
) (
   input  logic [61:0]     va_i,
   input  seg_e            seg_i,
   input  logic            erl_i,
   output logic [PA_W-1:0] pa_o,
   output logic            cached_o
);
   localparam logic [31:0] USER_BASE = 32'h4000_0000;
   localparam logic [2:0]  CCA_UNC   = 3'b010;

   logic [31:0] user_off;
   assign user_off = {1'b0, va_i[30:0]} + USER_BASE;

   always_comb begin
      pa_o     = '0;
      cached_o = 1'b0;
      unique case (seg_i)
         SEG_USER: begin
            pa_o     = erl_i ? PA_W'(va_i[31:0]) : PA_W'(user_off);
            cached_o = ~erl_i;
         end
         SEG_KCACHED: begin
            pa_o     = PA_W'(va_i[KSEG_KEEP-1:0]);
            cached_o = 1'b1;
         end
         SEG_KUNCACHED: begin
            pa_o     = PA_W'(va_i[KSEG_KEEP-1:0]);
            cached_o = 1'b0;
         end
         SEG_KUPPER: begin
            pa_o     = PA_W'(va_i[31:0]);
            cached_o = 1'b1;
         end
         SEG_XPHYS: begin
            pa_o     = PA_W'(va_i[XPHYS_TOP-1:0]);
            cached_o = (va_i[61:59] != CCA_UNC);
         end
         default: begin
            pa_o     = '0;
            cached_o = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/fixmap_xlat.sv
module fixmap_xlat
   import fixmap_pkg::*;
#(
   parameter int PA_W    = 59,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vld_i,
   input  logic [63:0]     vaddr_i,
   input  logic            narrow_i,
   input  logic            kern_i,
   input  logic            erl_i,
   output logic            vld_o,
   output logic [PA_W-1:0] paddr_o,
   output logic            cached_o,
   output logic            aerr_o
);
   generate
      if (PA_W < 32 || PA_W > XPHYS_TOP) begin : g_bad_pa_w
         $error("fixmap_xlat: PA_W must lie in 32..59");
      end
   endgenerate

   logic [63:0]     va_x;
   seg_e            seg;
   logic            fault;
   logic [PA_W-1:0] pa_raw;
   logic            cac_raw;
   logic            err_c, cac_c;
   logic [PA_W-1:0] pa_c;

   // narrow addresses are sign-extended from bit 31
   assign va_x = narrow_i ? {{32{vaddr_i[31]}}, vaddr_i[31:0]} : vaddr_i;

   fixmap_seg_decode #(.PA_W(PA_W)) u_dec (
      .va_hi_i (va_x[63:29]),
      .kern_i  (kern_i),
      .seg_o   (seg),
      .fault_o (fault)
   );

   fixmap_phys_form #(.PA_W(PA_W)) u_phy (
      .va_i     (va_x[61:0]),
      .seg_i    (seg),
      .erl_i    (erl_i),
      .pa_o     (pa_raw),
      .cached_o (cac_raw)
   );

   assign err_c = vld_i & fault;
   assign pa_c  = (vld_i & ~fault) ? pa_raw : '0;
   assign cac_c = vld_i & ~fault & cac_raw;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_o    <= 1'b0;
               paddr_o  <= '0;
               cached_o <= 1'b0;
               aerr_o   <= 1'b0;
            end else begin
               vld_o    <= vld_i;
               paddr_o  <= pa_c;
               cached_o <= cac_c;
               aerr_o   <= err_c;
            end
         end

         p_stage_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (vld_o == $past(vld_i) && aerr_o == $past(err_c)
                      && paddr_o == $past(pa_c)));
      end else begin : g_comb
         assign vld_o    = vld_i;
         assign paddr_o  = pa_c;
         assign cached_o = cac_c;
         assign aerr_o   = err_c;
      end
   endgenerate

   p_user_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !kern_i && va_x[63]) |-> (err_c && pa_c == '0 && !cac_c));

   p_kseg_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && kern_i && va_x[63:30] == {32'hFFFF_FFFF, 2'b10})
      |-> (!err_c && pa_c == PA_W'(va_x[28:0])));

   p_kseg_attr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && kern_i && va_x[63:30] == {32'hFFFF_FFFF, 2'b10})
      |-> (cac_c == !vaddr_i[29]));

   p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && narrow_i && kern_i && vaddr_i[31:30] == 2'b11)
      |-> (!err_c && pa_c == PA_W'(vaddr_i[31:0])));

   p_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !va_x[63] && va_x[62:31] != '0) |-> (err_c && pa_c == '0));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |-> (!err_c && pa_c == '0 && !cac_c));
endmodule

// File: tb/sim_fixmap_xlat.sv
`timescale 1ns/100ps
module sim_fixmap_xlat;
   localparam int PA_W = 48;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            vld_i = 1'b0;
   logic [63:0]     vaddr_i = '0;
   logic            narrow_i = 1'b0;
   logic            kern_i = 1'b0;
   logic            erl_i = 1'b0;
   logic            vld_o;
   logic [PA_W-1:0] paddr_o;
   logic            cached_o;
   logic            aerr_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   fixmap_xlat #(.PA_W(PA_W), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .vaddr_i(vaddr_i),
      .narrow_i(narrow_i), .kern_i(kern_i), .erl_i(erl_i),
      .vld_o(vld_o), .paddr_o(paddr_o), .cached_o(cached_o), .aerr_o(aerr_o)
   );

   function automatic void model(input logic [63:0] va, input logic nar,
                                 input logic kern, input logic erl,
                                 output logic e, output logic c,
                                 output logic [63:0] pa, output string rq);
      logic [63:0] v;
      v  = nar ? (va[31] ? (64'hFFFF_FFFF_0000_0000 | {32'h0, va[31:0]})
                         : {32'h0, va[31:0]}) : va;
      e  = 1'b0; c = 1'b0; pa = '0;
      if (v <= 64'h7FFF_FFFF) begin
         if (erl) begin pa = v; rq = "R7"; end
         else begin pa = v + 64'h4000_0000; c = 1'b1; rq = "R6"; end
      end else if (v < 64'h8000_0000_0000_0000) begin
         e = 1'b1; rq = "R9";
      end else if (!kern) begin
         e = 1'b1; rq = "R2";
      end else if (v <= 64'hBFFF_FFFF_FFFF_FFFF) begin
         pa = v % (64'h1 << 59);
         rq = "R8";
         if (pa >= (64'h1 << PA_W)) e = 1'b1;
         else c = (((v >> 59) % 8) != 2);
      end else if (v >= 64'hFFFF_FFFF_C000_0000) begin
         pa = v - 64'hFFFF_FFFF_0000_0000; c = 1'b1; rq = "R5";
      end else if (v >= 64'hFFFF_FFFF_A000_0000) begin
         pa = v - 64'hFFFF_FFFF_A000_0000; rq = "R4";
      end else if (v >= 64'hFFFF_FFFF_8000_0000) begin
         pa = v - 64'hFFFF_FFFF_8000_0000; c = 1'b1; rq = "R3";
      end else begin
         e = 1'b1; rq = "R9";
      end
      if (e) begin pa = '0; c = 1'b0; end
      if (nar) rq = {"R1/", rq};
   endfunction

   task automatic check(input string rq, input logic ev, input logic ee,
                        input logic ec, input logic [63:0] epa);
      n_chk++;
      if (vld_o !== ev || aerr_o !== ee || cached_o !== ec
          || paddr_o !== epa[PA_W-1:0]) begin
         n_err++;
         $display("FAIL %s va=%h: got vld=%b err=%b cac=%b pa=%h, exp vld=%b err=%b cac=%b pa=%h",
                  rq, vaddr_i, vld_o, aerr_o, cached_o, paddr_o,
                  ev, ee, ec, epa[PA_W-1:0]);
      end
   endtask

   // drive on the falling edge, the stage captures on the next rising edge,
   // sample on the falling edge after that
   task automatic run(input logic [63:0] va, input logic nar,
                      input logic kern, input logic erl);
      logic e, c;
      logic [63:0] pa;
      string rq;
      @(negedge clk);
      vld_i = 1'b1; vaddr_i = va; narrow_i = nar; kern_i = kern; erl_i = erl;
      model(va, nar, kern, erl, e, c, pa, rq);
      @(negedge clk);
      check(rq, 1'b1, e, c, pa);
   endtask

   logic [63:0] pts [18];

   initial begin
      pts[0]  = 64'h0000_0000_0000_0000;
      pts[1]  = 64'h0000_0000_7FFF_FFFF;
      pts[2]  = 64'h0000_0000_8000_0000;
      pts[3]  = 64'h7FFF_FFFF_FFFF_FFFF;
      pts[4]  = 64'h8000_0000_0000_0000;
      pts[5]  = 64'h9000_0000_1234_5678;
      pts[6]  = 64'h9800_0000_1234_5678;
      pts[7]  = 64'h9000_FFFF_0000_1234;
      pts[8]  = 64'hBFFF_FFFF_FFFF_FFFF;
      pts[9]  = 64'hC000_0000_0000_0000;
      pts[10] = 64'hFFFF_FFFF_7FFF_FFFF;
      pts[11] = 64'hFFFF_FFFF_8000_0000;
      pts[12] = 64'hFFFF_FFFF_9FFF_FFFF;
      pts[13] = 64'hFFFF_FFFF_A000_0000;
      pts[14] = 64'hFFFF_FFFF_BFC0_0000;
      pts[15] = 64'hFFFF_FFFF_BFFF_FFFF;
      pts[16] = 64'hFFFF_FFFF_C000_0000;
      pts[17] = 64'hFFFF_FFFF_FFFF_FFFF;

      // R10: reset state
      #1;
      check("R10", 1'b0, 1'b0, 1'b0, 64'h0);
      repeat (3) @(negedge clk);
      check("R10", 1'b0, 1'b0, 1'b0, 64'h0);
      rst_n = 1'b1;

      // R3: architectural anchor points
      run(64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1, 1'b0);
      if (paddr_o !== '0) begin n_err++; $display("FAIL R3 exception base pa=%h exp 0", paddr_o); end
      n_chk++;
      run(64'hFFFF_FFFF_BFC0_0000, 1'b0, 1'b1, 1'b0);
      if (paddr_o !== PA_W'(64'h1FC0_0000)) begin n_err++; $display("FAIL R3 reset vector pa=%h exp 1fc00000", paddr_o); end
      n_chk++;

      // full sweep: every boundary point, both modes, error level on/off,
      // wide and narrow (narrow with junk upper bits)
      for (int i = 0; i < 18; i++)
         for (int m = 0; m < 8; m++)
            run(m[2] ? {32'h5A5A_0F0F, pts[i][31:0]} : pts[i], m[2], m[0], m[1]);

      // R10: idle strobe gives all-zero outputs
      @(negedge clk);
      vld_i = 1'b0; vaddr_i = 64'hFFFF_FFFF_C000_1234; kern_i = 1'b1;
      @(negedge clk);
      check("R10", 1'b0, 1'b0, 1'b0, 64'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule